// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of one cache in a bus-based shared-memory multiprocessor, using a four-state invalidate protocol: Modified, Exclusive, Shared and Invalid. It reacts to two event streams. The first is local processor events: read, write and evict. The second is snooped bus events: bus read, bus write and bus upgrade. From these it produces bus requests, snoop responses, write-back strobes and state updates. Data storage, tag lookup, arbitration and memory are outside the block. They meet it only as a request/grant handshake, a sampled "other sharers present" signal and a write-back pulse.

A local request is held on `lcl_valid` until `lcl_done` pulses. Requests that need no bus transaction complete in the cycle they are seen. A request that needs the bus moves the local machine from `LF_IDLE` to `LF_WAIT`. The machine holds `bus_req` there until `bus_gnt`, and the line state changes in the grant cycle. A snoop always wins a cycle. It cancels a pending request back to `LF_IDLE`, and the held request is then decided again against the updated line state. Snoop responses, the error flag and the state update are combinational in the cycle of the snooped event.

Local transitions: read miss (I to E or S through a bus read), write miss (I to M through a bus write), upgrade (S to M through a bus upgrade), silent write (E to M), eviction (any valid state to I, with a write-back from M), and hits (no change). Snoop transitions: read-share (E to S), read-flush (M to S), write-kill (S or E to I), write-flush (M to I), upgrade-kill (S to I), and upgrade-fault (E or M, error).

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A state is encoded as I=2'b00, S=2'b01, E=2'b10, M=2'b11 on `upd_state`.
- R2: A local read (`lcl_op`=0) of an Invalid line raises `bus_req` with `bus_cmd`=0 (bus read) the cycle after acceptance. In the grant cycle the line becomes S if `bus_shared` is 1 and E otherwise.
- R3: A local write (`lcl_op`=1) to an Invalid line requests `bus_cmd`=1 (bus write). A local write to a Shared line requests `bus_cmd`=2 (upgrade). In both cases the line becomes M only in the grant cycle, when `lcl_done` pulses.
- R4: A local write to an Exclusive line moves it to M in the same cycle with no bus request.
- R5: Local reads of S, E or M lines and local writes to M lines complete in the same cycle with no bus request, no state update and no write-back.
- R6: A local evict (`lcl_op`=2) of an M line pulses `wb_pulse` with `wb_idx` equal to the line and moves it to I. Evicting an S or E line moves it to I without a write-back. Evicting an I line changes nothing.
- R7: A snooped bus read (`snp_cmd`=0) on an S or E line asserts `snp_resp_shared` and leaves the line in S. On an M line it asserts `snp_resp_dirty`, pulses a write-back of that line and moves it to S.
- R8: A snooped bus write (`snp_cmd`=1) moves an S or E line to I with no response. On an M line it responds dirty, writes back and moves the line to I.
- R9: A snooped upgrade (`snp_cmd`=2) moves an S line to I. On an E or M line it raises `err` and leaves the state unchanged.
- R10: Any snooped event on an Invalid line gives no response, no write-back, no error and no state update.
- R11: A snoop takes the cycle. `lcl_done` stays low, a grant in that cycle is not consumed, and the held local request is then decided again against the updated state.
- R12: `bus_req` stays high with a stable `bus_cmd` and `bus_idx` until a grant. `lcl_done` pulses once per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request present, held until `lcl_done` |
| lcl_op | input | 2 | Local operation: 0 read, 1 write, 2 evict, 3 no-op |
| lcl_idx | input | IDX_W | Line addressed by the local request |
| lcl_done | output | 1 | Local request completes this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Requested command: 0 read, 1 write, 2 upgrade |
| bus_idx | output | IDX_W | Line of the requested transaction |
| bus_gnt | input | 1 | Bus grant/acknowledge for the pending request |
| bus_shared | input | 1 | Other caches hold the line, sampled at grant |
| snp_valid | input | 1 | Snooped bus event present |
| snp_cmd | input | 2 | Snooped command: 0 read, 1 write, 2 upgrade |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| snp_resp_shared | output | 1 | Shared response to the snoop |
| snp_resp_dirty | output | 1 | Dirty response to the snoop |
| wb_pulse | output | 1 | One-cycle write-back strobe |
| wb_idx | output | IDX_W | Line being written back |
| err | output | 1 | Protocol error: upgrade snooped on an E or M line |
| upd_valid | output | 1 | A line state is written this cycle |
| upd_idx | output | IDX_W | Line being written |
| upd_state | output | 2 | New state of that line |

## Verification
The bench builds the block with `NUM_LINES` = 4. At that size every line can be driven through every starting state and every one of the six event kinds. Each line is first forced to a known state by an evict followed by a chosen fill, and then one event is applied. A second pass repeats this on reversed lines with the opposite sharers value, so the E and S fill outcomes are both reached on each line. Dedicated sequences cover snoops that cancel a pending upgrade, a snoop that changes nothing yet still holds off a grant, and a bus request held across cycles without a grant.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        LOP_RD  = 2'd0,
        LOP_WR  = 2'd1,
        LOP_EV  = 2'd2,
        LOP_NOP = 2'd3
    } lop_t;

    typedef enum logic [1:0] {
        BC_RD   = 2'd0,
        BC_WR   = 2'd1,
        BC_UPG  = 2'd2,
        BC_NONE = 2'd3
    } bcmd_t;

    typedef enum logic {
        LF_IDLE = 1'b0,
        LF_WAIT = 1'b1
    } lfsm_t;

    typedef struct packed {
        logic     shared;
        logic     dirty;
        logic     wb;
        logic     err;
        logic     wr;
        line_st_t nxt;
    } snp_act_t;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output line_st_t         ra_st,
    input  logic [IDX_W-1:0] rb_idx,
    output line_st_t         rb_st,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  line_st_t         w_st
);

    line_st_t st_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= ST_I;
            end else if (we && (w_idx == IDX_W'(g))) begin
                st_q[g] <= w_st;
            end
        end
    end

    always_comb begin
        ra_st = st_q[ra_idx];
        rb_st = st_q[rb_idx];
    end

endmodule

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
    import mesi_pkg::*;
(
    input  logic     vld,
    input  bcmd_t    cmd,
    input  line_st_t cur,
    output snp_act_t act
);

    always_comb begin
        act        = '0;
        act.nxt    = cur;
        if (vld && (cur != ST_I)) begin
            unique case (cmd)
                BC_RD: begin
                    unique case (cur)
                        ST_S: act.shared = 1'b1;
                        ST_E: begin
                            act.shared = 1'b1;
                            act.wr     = 1'b1;
                            act.nxt    = ST_S;
                        end
                        ST_M: begin
                            act.dirty  = 1'b1;
                            act.wb     = 1'b1;
                            act.wr     = 1'b1;
                            act.nxt    = ST_S;
                        end
                        default: ;
                    endcase
                end
                BC_WR: begin
                    act.wr  = 1'b1;
                    act.nxt = ST_I;
                    if (cur == ST_M) begin
                        act.dirty = 1'b1;
                        act.wb    = 1'b1;
                    end
                end
                BC_UPG: begin
                    if (cur == ST_S) begin
                        act.wr  = 1'b1;
                        act.nxt = ST_I;
                    end else begin
                        act.err = 1'b1;
                    end
                end
                BC_NONE: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcl_valid,
    input  lop_t             lcl_op,
    input  logic [IDX_W-1:0] lcl_idx,
    input  line_st_t         cur_st,
    input  logic             snp_valid,
    input  logic             bus_gnt,
    input  logic             bus_shared,
    output logic             lcl_done,
    output logic             bus_req,
    output bcmd_t            bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    output logic             wr,
    output line_st_t         wr_st,
    output logic             wb
);

    lfsm_t            fsm_q, fsm_d;
    bcmd_t            cmd_q, cmd_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= LF_IDLE;
            cmd_q <= BC_NONE;
            idx_q <= '0;
        end else begin
            fsm_q <= fsm_d;
            cmd_q <= cmd_d;
            if (fsm_q == LF_IDLE && fsm_d == LF_WAIT) begin
                idx_q <= lcl_idx;
            end
        end
    end

    always_comb begin
        fsm_d    = fsm_q;
        cmd_d    = cmd_q;
        lcl_done = 1'b0;
        wr       = 1'b0;
        wr_st    = ST_I;
        wb       = 1'b0;
        unique case (fsm_q)
            LF_IDLE: begin
                if (lcl_valid && !snp_valid) begin
                    unique case (lcl_op)
                        LOP_RD: begin
                            if (cur_st == ST_I) begin
                                fsm_d = LF_WAIT;
                                cmd_d = BC_RD;
                            end else begin
                                lcl_done = 1'b1;
                            end
                        end
                        LOP_WR: begin
                            unique case (cur_st)
                                ST_I: begin
                                    fsm_d = LF_WAIT;
                                    cmd_d = BC_WR;
                                end
                                ST_S: begin
                                    fsm_d = LF_WAIT;
                                    cmd_d = BC_UPG;
                                end
                                ST_E: begin
                                    lcl_done = 1'b1;
                                    wr       = 1'b1;
                                    wr_st    = ST_M;
                                end
                                ST_M: lcl_done = 1'b1;
                            endcase
                        end
                        LOP_EV: begin
                            lcl_done = 1'b1;
                            if (cur_st != ST_I) begin
                                wr    = 1'b1;
                                wr_st = ST_I;
                                wb    = (cur_st == ST_M);
                            end
                        end
                        LOP_NOP: lcl_done = 1'b1;
                    endcase
                end
            end
            LF_WAIT: begin
                if (snp_valid) begin
                    fsm_d = LF_IDLE;
                end else if (bus_gnt) begin
                    lcl_done = 1'b1;
                    wr       = 1'b1;
                    fsm_d    = LF_IDLE;
                    if (cmd_q == BC_RD) begin
                        wr_st = bus_shared ? ST_S : ST_E;
                    end else begin
                        wr_st = ST_M;
                    end
                end
            end
        endcase
    end

    always_comb begin
        bus_req = (fsm_q == LF_WAIT);
        bus_cmd = cmd_q;
        bus_idx = idx_q;
    end

    // R12: a request without grant is held unchanged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_cmd) && $stable(bus_idx)));

    // R11: a snoop cycle never completes a local request
    a_r11_snoop_defers: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !lcl_done);

    // R3: an unblocked grant completes the pending request and releases the bus
    a_r3_grant_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !snp_valid) |-> (lcl_done ##1 !bus_req));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcl_valid,
    input  logic [1:0]       lcl_op,
    input  logic [IDX_W-1:0] lcl_idx,
    output logic             lcl_done,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_gnt,
    input  logic             bus_shared,
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_resp_shared,
    output logic             snp_resp_dirty,
    output logic             wb_pulse,
    output logic [IDX_W-1:0] wb_idx,
    output logic             err,
    output logic             upd_valid,
    output logic [IDX_W-1:0] upd_idx,
    output logic [1:0]       upd_state
);

    line_st_t         snp_cur, lcl_cur, w_st;
    snp_act_t         sact;
    logic             lf_wr, lf_wb, we;
    line_st_t         lf_wr_st;
    bcmd_t            lf_cmd;
    logic [IDX_W-1:0] w_idx;

    mesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (snp_idx),
        .ra_st  (snp_cur),
        .rb_idx (lcl_idx),
        .rb_st  (lcl_cur),
        .we     (we),
        .w_idx  (w_idx),
        .w_st   (w_st)
    );

    mesi_snoop_eval u_snoop (
        .vld (snp_valid),
        .cmd (bcmd_t'(snp_cmd)),
        .cur (snp_cur),
        .act (sact)
    );

    mesi_local_fsm #(.IDX_W(IDX_W)) u_local (
        .clk        (clk),
        .rst_n      (rst_n),
        .lcl_valid  (lcl_valid),
        .lcl_op     (lop_t'(lcl_op)),
        .lcl_idx    (lcl_idx),
        .cur_st     (lcl_cur),
        .snp_valid  (snp_valid),
        .bus_gnt    (bus_gnt),
        .bus_shared (bus_shared),
        .lcl_done   (lcl_done),
        .bus_req    (bus_req),
        .bus_cmd    (lf_cmd),
        .bus_idx    (bus_idx),
        .wr         (lf_wr),
        .wr_st      (lf_wr_st),
        .wb         (lf_wb)
    );

    always_comb begin
        bus_cmd         = lf_cmd;
        we              = sact.wr | lf_wr;
        w_idx           = sact.wr ? snp_idx : lcl_idx;
        w_st            = sact.wr ? sact.nxt : lf_wr_st;
        snp_resp_shared = sact.shared;
        snp_resp_dirty  = sact.dirty;
        err             = sact.err;
        wb_pulse        = sact.wb | lf_wb;
        wb_idx          = sact.wb ? snp_idx : lcl_idx;
        upd_valid       = we;
        upd_idx         = w_idx;
        upd_state       = w_st;
    end

    // R7: a dirty response always comes with a write-back of the snooped line
    a_r7_dirty_wb: assert property (@(posedge clk) disable iff (!rst_n)
        snp_resp_dirty |-> (wb_pulse && wb_idx == snp_idx));

    // R9: an upgrade fault leaves every line untouched
    a_r9_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !upd_valid);

    // R10: the two snoop responses are never given together
    a_r10_resp_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_resp_shared && snp_resp_dirty));

    // R11: local and snoop paths never both touch state in one cycle
    a_r11_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !lcl_done);

endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;

    localparam int NL = 4;
    localparam int IW = 2;
    localparam int SI = 0, SS = 1, SE = 2, SM = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lcl_valid = 1'b0;
    logic [1:0]    lcl_op = 2'd0;
    logic [IW-1:0] lcl_idx = '0;
    logic          lcl_done, bus_req;
    logic [1:0]    bus_cmd;
    logic [IW-1:0] bus_idx;
    logic          bus_gnt = 1'b0, bus_shared = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_resp_shared, snp_resp_dirty, wb_pulse, err, upd_valid;
    logic [IW-1:0] wb_idx, upd_idx;
    logic [1:0]    upd_state;

    int n_cmp = 0;
    int n_bad = 0;
    int model [NL];
    int cycles = 0;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_idx(lcl_idx), .lcl_done(lcl_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
        .bus_gnt(bus_gnt), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .snp_resp_shared(snp_resp_shared), .snp_resp_dirty(snp_resp_dirty),
        .wb_pulse(wb_pulse), .wb_idx(wb_idx), .err(err),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_state(upd_state)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input string what, input int act, input int exp);
        chk(act == exp, tag, what, act, exp);
    endtask

    // expected update check: new state written only on a change
    task automatic chk_upd(input string tag, input int idx, input int cur, input int nxt);
        chk_eq(tag, "upd_valid", int'(upd_valid), int'(nxt != cur));
        if (nxt != cur) begin
            chk_eq(tag, "upd_idx", int'(upd_idx), idx);
            chk_eq(tag, "upd_state", int'(upd_state), nxt);
        end
    endtask

    task automatic do_local(input int op, input int idx, input bit shr);
        int    cur, nxt, cmd;
        bit    need_bus, exp_wb;
        string tag;
        cur = model[idx];
        nxt = cur;
        exp_wb = 1'b0;
        need_bus = 1'b0;
        cmd = 3;
        tag = "R5";
        if (op == 0) begin
            if (cur == SI) begin need_bus = 1'b1; cmd = 0; tag = "R2"; end
        end else if (op == 1) begin
            if (cur == SI)      begin need_bus = 1'b1; cmd = 1; tag = "R3"; end
            else if (cur == SS) begin need_bus = 1'b1; cmd = 2; tag = "R3"; end
            else if (cur == SE) begin nxt = SM; tag = "R4"; end
        end else if (op == 2) begin
            tag = "R6";
            nxt = SI;
            exp_wb = (cur == SM);
        end
        @(negedge clk);
        lcl_valid = 1'b1; lcl_op = 2'(op); lcl_idx = IW'(idx);
        #2;
        chk_eq(tag, "bus_req at accept", int'(bus_req), 0);
        if (!need_bus) begin
            chk_eq(tag, "lcl_done", int'(lcl_done), 1);
            chk_eq(tag, "wb_pulse", int'(wb_pulse), int'(exp_wb));
            if (exp_wb) chk_eq(tag, "wb_idx", int'(wb_idx), idx);
            chk_upd(tag, idx, cur, nxt);
        end else begin
            chk_eq(tag, "lcl_done before grant", int'(lcl_done), 0);
            @(negedge clk); #2;
            chk_eq(tag, "bus_req", int'(bus_req), 1);
            chk_eq(tag, "bus_cmd", int'(bus_cmd), cmd);
            chk_eq(tag, "bus_idx", int'(bus_idx), idx);
            chk_eq("R12", "no done without grant", int'(lcl_done), 0);
            @(negedge clk); #2;
            chk_eq("R12", "bus_req held", int'(bus_req), 1);
            chk_eq("R12", "bus_cmd held", int'(bus_cmd), cmd);
            bus_gnt = 1'b1; bus_shared = shr;
            #1;
            nxt = (cmd == 0) ? (shr ? SS : SE) : SM;
            chk_eq(tag, "lcl_done at grant", int'(lcl_done), 1);
            chk_upd(tag, idx, cur, nxt);
        end
        model[idx] = nxt;
        @(negedge clk);
        lcl_valid = 1'b0; bus_gnt = 1'b0; bus_shared = 1'b0;
        #2;
        chk_eq("R12", "bus_req released", int'(bus_req), 0);
    endtask

    task automatic do_snoop(input int cmd, input int idx);
        int    cur, nxt;
        bit    e_sh, e_dt, e_wb, e_err;
        string tag;
        cur = model[idx];
        nxt = cur;
        e_sh = 0; e_dt = 0; e_wb = 0; e_err = 0;
        if (cur == SI) tag = "R10";
        else if (cmd == 0) begin
            tag = "R7";
            if (cur == SM) begin e_dt = 1; e_wb = 1; end else e_sh = 1;
            nxt = SS;
        end else if (cmd == 1) begin
            tag = "R8";
            if (cur == SM) begin e_dt = 1; e_wb = 1; end
            nxt = SI;
        end else begin
            tag = "R9";
            if (cur == SS) nxt = SI; else e_err = 1;
        end
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_idx = IW'(idx);
        #2;
        chk_eq(tag, "snp_resp_shared", int'(snp_resp_shared), int'(e_sh));
        chk_eq(tag, "snp_resp_dirty", int'(snp_resp_dirty), int'(e_dt));
        chk_eq(tag, "wb_pulse", int'(wb_pulse), int'(e_wb));
        if (e_wb) chk_eq(tag, "wb_idx", int'(wb_idx), idx);
        chk_eq(tag, "err", int'(err), int'(e_err));
        chk_upd(tag, idx, cur, nxt);
        model[idx] = nxt;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic set_state(input int idx, input int s);
        do_local(2, idx, 1'b0);
        if (s == SS) do_local(0, idx, 1'b1);
        else if (s == SE) do_local(0, idx, 1'b0);
        else if (s == SM) do_local(1, idx, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) model[i] = SI;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk_eq("R1", "bus_req after reset", int'(bus_req), 0);
        chk_eq("R1", "lcl_done after reset", int'(lcl_done), 0);
        // every line starts Invalid: a snooped read finds nothing
        for (int i = 0; i < NL; i++) do_snoop(0, i);

        // near-exhaustive: every line, every start state, every event
        for (int idx = 0; idx < NL; idx++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ev = 0; ev < 6; ev++) begin
                    set_state(idx, s);
                    if (ev < 3) do_local(ev, idx, 1'b1);
                    else do_snoop(ev - 3, idx);
                end
            end
        end
        // second pass with the opposite sharers value on fills
        for (int idx = NL - 1; idx >= 0; idx--) begin
            for (int ev = 0; ev < 3; ev++) begin
                set_state(idx, SI);
                do_local(ev, idx, 1'b0);
            end
        end

        // R11: snoop kill of a pending upgrade, then re-decision as a bus write
        set_state(1, SS);
        @(negedge clk);
        lcl_valid = 1'b1; lcl_op = 2'd1; lcl_idx = 2'd1;
        @(negedge clk); #2;
        chk_eq("R11", "upgrade requested", int'(bus_cmd), 2);
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 2'd1; bus_gnt = 1'b1;
        #1;
        chk_eq("R11", "no done while snooped", int'(lcl_done), 0);
        chk_eq("R11", "snoop write kills line", int'(upd_state), SI);
        @(negedge clk);
        snp_valid = 1'b0; bus_gnt = 1'b0;
        #2;
        chk_eq("R11", "request withdrawn", int'(bus_req), 0);
        @(negedge clk); #2;
        chk_eq("R11", "re-decided as bus write", int'(bus_cmd), 1);
        chk_eq("R11", "bus_req again", int'(bus_req), 1);
        bus_gnt = 1'b1;
        #1;
        chk_eq("R11", "done after regrant", int'(lcl_done), 1);
        chk_eq("R11", "line modified", int'(upd_state), SM);
        @(negedge clk);
        lcl_valid = 1'b0; bus_gnt = 1'b0;
        model[1] = SM;

        // R11: a snoop to another line still holds off the grant
        set_state(2, SI);
        @(negedge clk);
        lcl_valid = 1'b1; lcl_op = 2'd0; lcl_idx = 2'd2;
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_idx = 2'd0; bus_gnt = 1'b1;
        #2;
        chk_eq("R11", "grant not consumed", int'(lcl_done), 0);
        @(negedge clk);
        snp_valid = 1'b0; bus_gnt = 1'b0;
        @(negedge clk); #2;
        chk_eq("R11", "read re-requested", int'(bus_req), 1);
        bus_gnt = 1'b1; bus_shared = 1'b0;
        #1;
        chk_eq("R11", "fill exclusive", int'(upd_state), SE);
        @(negedge clk);
        lcl_valid = 1'b0; bus_gnt = 1'b0;
        model[2] = SE;

        // R1: encodings seen directly on the update port
        do_snoop(0, 2);
        do_local(1, 2, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule